// File: doc/BRIEF.md
# Two-Stage Configurable Transceiver Datapath

This block is a non-inverting, two-stage data path for a backplane transceiver. Data arriving on the input port A is held by a first storage stage. That stage drives the bidirectional port B through open-drain drivers. A second storage stage feeds the output port C. Each stage is configured at run time as one of two types. The first type is an edge-triggered register, loaded when its stage clock rises. The second is a level-sensitive latch, which is transparent while its stage clock is high and holds while it is low.

A source select sets where the second stage reads from. It can read the first stage's value directly, which is a diagnostic loopback that never touches the backplane. It can also read the value seen on the B pins, which includes any wired-OR pull-down from other drivers. Both output ports have an active-low enable.

The whole block runs on a fast system clock. The stage clocks are sampled on that clock, so they act as load conditions. A stage loads at a system edge where its stage clock is sampled high. In register mode, the stage clock must also have been sampled low on the system edge before.

Top module: `bus_xcvr_dp`

## Requirements
- R1: While `rst_n` is low, both stages clear to 0. After reset, port B pulls every bit low when enabled, and `c_data` reads 0.
- R2: With `s1_latch`=0 (register mode), stage 1 loads `a_in` at a system clock edge where `stage1_clk` is sampled 1, provided it was sampled 0 at the edge before.
- R3: In register mode, a stage keeps its value while its stage clock stays high or stays low, whatever its data input does.
- R4: With `s1_latch`=1 (latch mode), stage 1 loads `a_in` at every system edge where `stage1_clk` is 1. While `stage1_clk` is 0, it holds the last value loaded.
- R5: Stage 2 follows the same two modes, using `s2_latch` and `stage2_clk`.
- R6: Port B is open drain. `b_drive_low[i]` is 1 exactly when stage-1 bit i is 0 and `b_oe_n` is 0. A 1 is never driven; a bit that is not pulled low is released to the external termination.
- R7: With `b_oe_n`=1, every bit of `b_drive_low` is 0, so all B drivers are released.
- R8: `c_en` is 1 only when `c_oe_n` is 0. With `c_en`=0, the C outputs are high impedance.
- R9: With `fb_from_pins`=0, stage 2 reads stage 1's value. The B pin levels then have no effect on it.
- R10: With `fb_from_pins`=1, stage 2 reads `b_pin_in`. This includes bits pulled low by other drivers on the wired-OR bus.
- R11: Every path is non-inverting. A value loaded into stage 1 reaches `c_data` unchanged through the internal path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Port A data input |
| stage1_clk | input | 1 | Stage-1 clock (edge in register mode, level in latch mode) |
| stage2_clk | input | 1 | Stage-2 clock |
| s1_latch | input | 1 | Stage-1 mode: 0 register, 1 latch |
| s2_latch | input | 1 | Stage-2 mode: 0 register, 1 latch |
| fb_from_pins | input | 1 | Stage-2 source: 0 internal stage-1 value, 1 B pins |
| b_oe_n | input | 1 | Port B enable, active low |
| c_oe_n | input | 1 | Port C enable, active low |
| b_pin_in | input | W | Sampled B pin levels |
| b_drive_low | output | W | Per-bit open-drain pull-down enable for port B |
| c_data | output | W | Port C data (stage-2 value) |
| c_en | output | 1 | Port C drive enable; 0 means high impedance |

## Verification
A stage clock change and the data applied with it produce a stage load at the next rising system edge. The stage-1 result appears on `b_drive_low` right after that edge. A stage-2 result appears on `c_data` after that edge as well. With the internal path and stage 2 in latch mode, stage 2 picks up a new stage-1 value one system edge later. The enables and the open-drain gating act within the same cycle. The bench changes every input on the falling edge of the system clock and samples on a later falling edge. It waits one edge per register in the path, and two edges for the stage-1 to stage-2 latch chain.

// File: rtl/xcvr_dp_pkg.sv
package xcvr_dp_pkg;

  typedef enum logic {
    MODE_REG   = 1'b0,
    MODE_LATCH = 1'b1
  } stage_mode_e;

  // Load condition of one stage from its sampled clock levels
  function automatic logic stage_loads(stage_mode_e mode, logic clk_now, logic clk_prev);
    if (mode == MODE_LATCH) return clk_now;
    return clk_now & ~clk_prev;
  endfunction

  // Open-drain pull-down request for one bit
  function automatic logic od_pull(logic bit_val, logic oe_n);
    return ~bit_val & ~oe_n;
  endfunction

endpackage

// File: rtl/xcvr_stage.sv
module xcvr_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stg_clk,
  input  logic         latch_mode,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         load
);
  import xcvr_dp_pkg::*;

  logic stg_clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_clk_q <= 1'b0;
    else        stg_clk_q <= stg_clk;
  end

  assign load = stage_loads(stage_mode_e'(latch_mode), stg_clk, stg_clk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_od_port.sv
module xcvr_od_port #(
  parameter int W = 10
) (
  input  logic [W-1:0] val,
  input  logic         oe_n,
  output logic [W-1:0] pull_low
);
  import xcvr_dp_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pull_low[i] = od_pull(val[i], oe_n);
  end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
  parameter int W = 10
) (
  input  logic         from_pins,
  input  logic [W-1:0] internal_val,
  input  logic [W-1:0] pin_val,
  output logic [W-1:0] sel_val
);
  assign sel_val = from_pins ? pin_val : internal_val;
endmodule

// File: rtl/bus_xcvr_dp.sv
module bus_xcvr_dp #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         stage1_clk,
  input  logic         stage2_clk,
  input  logic         s1_latch,
  input  logic         s2_latch,
  input  logic         fb_from_pins,
  input  logic         b_oe_n,
  input  logic         c_oe_n,
  input  logic [W-1:0] b_pin_in,
  output logic [W-1:0] b_drive_low,
  output logic [W-1:0] c_data,
  output logic         c_en
);
  logic [W-1:0] q1, q2, d2;
  logic         s1_load, s2_load;

  xcvr_stage #(.W(W)) u_stage1 (
    .clk(clk), .rst_n(rst_n), .stg_clk(stage1_clk), .latch_mode(s1_latch),
    .d(a_in), .q(q1), .load(s1_load)
  );

  xcvr_od_port #(.W(W)) u_bport (
    .val(q1), .oe_n(b_oe_n), .pull_low(b_drive_low)
  );

  xcvr_src_mux #(.W(W)) u_mux (
    .from_pins(fb_from_pins), .internal_val(q1), .pin_val(b_pin_in), .sel_val(d2)
  );

  xcvr_stage #(.W(W)) u_stage2 (
    .clk(clk), .rst_n(rst_n), .stg_clk(stage2_clk), .latch_mode(s2_latch),
    .d(d2), .q(q2), .load(s2_load)
  );

  assign c_data = q2;
  assign c_en   = ~c_oe_n;
endmodule

// File: rtl/xcvr_dp_chk.sv
module xcvr_dp_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic         stage1_clk,
  input logic         s1_latch,
  input logic         fb_from_pins,
  input logic         b_oe_n,
  input logic [W-1:0] b_drive_low,
  input logic [W-1:0] q1,
  input logic [W-1:0] q2,
  input logic         s1_load,
  input logic         s2_load
);
  // R2/R4: a stage-1 load takes the port A value
  p_s1_load_takes_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_load |=> q1 == $past(a_in));

  // R3: without a load, stage 1 keeps its value
  p_s1_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_load |=> $stable(q1));

  // R3: without a load, stage 2 keeps its value
  p_s2_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_load |=> $stable(q2));

  // R4: latch mode with clock high always loads
  p_latch_transparent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_latch && stage1_clk) |-> s1_load);

  // R7: disabled B port releases every driver
  p_b_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe_n |-> b_drive_low == '0);

  // R6: enabled B port pulls low exactly the zero bits
  p_open_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe_n |-> b_drive_low == ~q1);

  // R9: internal path loads stage 1 value into stage 2
  p_internal_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_load && !fb_from_pins) |=> q2 == $past(q1));
endmodule

bind bus_xcvr_dp xcvr_dp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .stage1_clk(stage1_clk),
  .s1_latch(s1_latch), .fb_from_pins(fb_from_pins), .b_oe_n(b_oe_n),
  .b_drive_low(b_drive_low), .q1(q1), .q2(q2), .s1_load(s1_load), .s2_load(s2_load)
);

// File: tb/sim_bus_xcvr_dp.sv
module sim_bus_xcvr_dp;
  localparam int W = 10;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic         stage1_clk = 1'b0, stage2_clk = 1'b0;
  logic         s1_latch = 1'b0, s2_latch = 1'b0;
  logic         fb_from_pins = 1'b0;
  logic         b_oe_n = 1'b1, c_oe_n = 1'b1;
  logic [W-1:0] ext_low = '0;
  logic [W-1:0] b_pin_in;
  logic [W-1:0] b_drive_low, c_data;
  logic         c_en;
  int checks = 0, fails = 0;
  logic [W-1:0] exp1 = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // External termination pulls high; our driver or another bus driver pulls low
  assign b_pin_in = ~(b_drive_low | ext_low);

  bus_xcvr_dp #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .stage1_clk(stage1_clk),
    .stage2_clk(stage2_clk), .s1_latch(s1_latch), .s2_latch(s2_latch),
    .fb_from_pins(fb_from_pins), .b_oe_n(b_oe_n), .c_oe_n(c_oe_n),
    .b_pin_in(b_pin_in), .b_drive_low(b_drive_low), .c_data(c_data), .c_en(c_en)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    b_oe_n = 1'b0;
    tick();
    check("R1 B pulls all low", b_drive_low, '1);
    check("R1 C reads zero", c_data, '0);
  endtask

  task automatic t_reg1;
    s1_latch = 1'b0;
    a_in = 10'h2A5; stage1_clk = 1'b1;
    tick();
    exp1 = 10'h2A5;
    check("R2 register load", b_drive_low, ~exp1);
    check("R6 open drain per bit", b_pin_in, exp1);
    a_in = 10'h155;
    tick(2);
    check("R3 hold with clock high", b_drive_low, ~exp1);
    stage1_clk = 1'b0;
    tick(2);
    check("R3 hold with clock low", b_drive_low, ~exp1);
  endtask

  task automatic t_latch1;
    s1_latch = 1'b1;
    a_in = 10'h0F0; stage1_clk = 1'b1;
    tick();
    check("R4 transparent first", b_drive_low, ~10'h0F0);
    a_in = 10'h30C;
    tick();
    check("R4 transparent follows", b_drive_low, ~10'h30C);
    stage1_clk = 1'b0; a_in = 10'h3FF;
    tick(2);
    exp1 = 10'h30C;
    check("R4 latch holds", b_drive_low, ~exp1);
  endtask

  task automatic t_boe;
    b_oe_n = 1'b1;
    tick();
    check("R7 drivers released", b_drive_low, '0);
  endtask

  task automatic t_fb_internal;
    ext_low = '1; fb_from_pins = 1'b0; s2_latch = 1'b0; c_oe_n = 1'b0;
    stage2_clk = 1'b1;
    tick();
    stage2_clk = 1'b0;
    check("R9 internal path ignores pins", c_data, exp1);
    check("R11 non-inverting A to C", c_data, 10'h30C);
    check("R8 C enabled", {{(W-1){1'b0}}, c_en}, 1);
    tick();
  endtask

  task automatic t_fb_pins;
    b_oe_n = 1'b0; ext_low = 10'h004; fb_from_pins = 1'b1;
    tick();
    check("R10 wired-OR pin level", b_pin_in, 10'h308);
    stage2_clk = 1'b1;
    tick();
    stage2_clk = 1'b0;
    check("R10 stage 2 reads pins", c_data, 10'h308);
    ext_low = '0;
    tick(2);
    check("R3 stage 2 holds in register mode", c_data, 10'h308);
  endtask

  task automatic t_latch2;
    fb_from_pins = 1'b0; s2_latch = 1'b1; s1_latch = 1'b1;
    stage1_clk = 1'b1; stage2_clk = 1'b1; a_in = 10'h111;
    tick(2);
    check("R5 stage 2 latch transparent", c_data, 10'h111);
    stage1_clk = 1'b0; stage2_clk = 1'b0;
    tick();
    stage1_clk = 1'b1; a_in = 10'h2C3;
    tick(2);
    stage1_clk = 1'b0;
    check("R5 stage 1 updated", b_drive_low, ~10'h2C3);
    check("R5 stage 2 latch holds", c_data, 10'h111);
  endtask

  task automatic t_coe;
    c_oe_n = 1'b1;
    tick();
    check("R8 C high impedance", {{(W-1){1'b0}}, c_en}, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    t_reset();
    t_reg1();
    t_latch1();
    t_boe();
    t_fb_internal();
    t_fb_pins();
    t_latch2();
    t_coe();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule